// File: doc/BRIEF.md
# VME Slave Cycle Address Decoder

This block sits behind the VME slave port of a carrier that hosts four mezzanine sites. On each slave cycle it looks at the address modifier code, the address lines and the transfer width. It compares the upper address bits with either the 5-bit slot/jumper address or a software-loaded memory base, and names exactly one target region. The regions are:

- the I/O space, ID space or memory window of one site;
- the on-board register block;
- the DSP control block;
- the shared RAM window;
- the carrier identification area;
- the configuration ROM.

Alongside the select it reports the offset of the access inside that region, counted in 16-bit or 32-bit units. The transfer-acknowledge logic uses the one-bit claim output to decide whether to answer the cycle. The data path uses the selects and the offset to steer the access.

Three address spaces are handled. The short (16-bit) and standard (24-bit) spaces reach a 2 KB register window. The extended (32-bit) space reaches the site memories. Each site's memory window can be 1, 2, 4 or 8 MB. The four windows lie back to back from a base. That base comes either from the slot address or from an offset register, and the window size changes which address bits take part in the comparison. The decode is taken once, at the first clock that sees the address strobe fall, and is held until the strobe goes high.

Top module: `vmeSlaveDecode`

## Requirements
- R1: With amCode 0x29 or 0x2D (short space), the register window is hit when vmeAddr[15:11] equals slotAddr.
- R2: With amCode 0x39 or 0x3D (standard space), the register window is hit when vmeAddr[23:19] equals slotAddr.
- R3: Inside a hit register window, the byte offset A10..A0 is decoded as follows:
  - site n (n = 0..3, site A is 0) owns 0x100*n..0x100*n+0x07F as I/O and the next 128 bytes as ID;
  - 0x400-0x41F selects the on-board registers;
  - 0x420-0x43F selects the DSP control block;
  - 0x440-0x47F selects the shared RAM;
  - 0x480-0x4FF selects the carrier ID area;
  - 0x600-0x7FF selects the configuration ROM;
  - 0x500-0x5FF selects nothing.
- R4: amCode 0x2F uses the standard-space comparison of R2, but only the 0x600-0x7FF range selects (the configuration ROM); every other offset selects nothing.
- R5: With amCode 0x09 or 0x0D and memBaseSel=1, a site is hit when the address bits from bit 22+memSize up to bit 31 equal the same bits of {offsetReg,16'h0}. Lower offsetReg bits are ignored. The site index is taken from the two address bits starting at bit 20+memSize. The window is 1 MB << memSize.
- R6: With a memory AM and memBaseSel=0, the slot comparison depends on memSize:
  - memSize 0: slotAddr is compared with A26..A22, and A31..A27 must be zero;
  - memSize 1: slotAddr is compared with A27..A23, and A31..A28 must be zero;
  - memSize 3: slotAddr is compared with A31..A27, and A26..A25 must be zero;
  - memSize 2: nothing is selected.
- R7: wordOff is the address inside the selected region divided by 2 when lwordN=1, or by 4 when lwordN=0. It is 0 when nothing is selected.
- R8: Any other amCode, a cycle whose address falls outside every region, or a cycle begun with iackN low selects nothing and leaves claim low.
- R9: Selects are loaded at the first clock edge that samples asN low after it was high. They are held while asN stays low, whatever the inputs do. They clear at the first clock edge that samples asN high.
- R10: After reset every output is 0. At most one select is ever active, and claim is high exactly when one is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock |
| rstN | input | 1 | Asynchronous active-low reset |
| asN | input | 1 | Address strobe, active low |
| iackN | input | 1 | Interrupt-acknowledge qualifier, active low |
| lwordN | input | 1 | Low for a 32-bit transfer |
| amCode | input | 6 | Address modifier |
| vmeAddr | input | 31 | Address lines A31..A1 |
| slotAddr | input | 5 | Slot or jumper module address |
| offsetReg | input | 16 | Memory base register, bits 15..6 = A31..A22 |
| memBaseSel | input | 1 | 0 = slot-address base, 1 = offset-register base |
| memSize | input | 2 | Site window size code, 1 MB << code |
| selIo | output | 4 | Per-site I/O space select |
| selId | output | 4 | Per-site ID space select |
| selMem | output | 4 | Per-site memory window select |
| selRegs | output | 1 | On-board register block select |
| selDsp | output | 1 | DSP control block select |
| selRam | output | 1 | Shared RAM select |
| selCarrierId | output | 1 | Carrier ID area select |
| selCfgRom | output | 1 | Configuration ROM select |
| wordOff | output | 22 | Offset inside the selected region |
| claim | output | 1 | The cycle belongs to this slave |

## Verification
The hardest case to reach from the ports is the hold behaviour. The design must ignore a changed address, modifier and base configuration while the strobe stays low. That change can only be presented after a capture has already happened. The bench therefore opens a valid cycle and lets it capture. It then drives an address that matches nothing, with a new modifier, for two more clocks, and checks that the original select and offset are still present. The memory-size corner cases are reached by reprogramming memSize and memBaseSel between cycles. Each case uses an address crafted so that only the bits the active size compares decide the outcome, for example setting the offset register bits below the span to show they are ignored.

// File: rtl/vme_dec_pkg.sv
package vme_dec_pkg;
  localparam int NUM_SITES  = 4;
  localparam int SLOT_W     = 5;
  localparam int AM_W       = 6;
  localparam int ADDR_HI    = 31;
  localparam int OFSREG_W   = 16;
  localparam int SIZE_W     = 2;
  localparam int SITE_IDX_W = $clog2(NUM_SITES);
  localparam int HALF_OFF_W = 22;

  localparam logic [AM_W-1:0] AM_SHORT_USER = 6'h29;
  localparam logic [AM_W-1:0] AM_SHORT_SUP  = 6'h2D;
  localparam logic [AM_W-1:0] AM_STD_USER   = 6'h39;
  localparam logic [AM_W-1:0] AM_STD_SUP    = 6'h3D;
  localparam logic [AM_W-1:0] AM_CFG_ROM    = 6'h2F;
  localparam logic [AM_W-1:0] AM_EXT_USER   = 6'h09;
  localparam logic [AM_W-1:0] AM_EXT_SUP    = 6'h0D;

  typedef struct packed {
    logic capture;
    logic clear;
  } decStrobe_t;

  typedef struct packed {
    logic [NUM_SITES-1:0]  io;
    logic [NUM_SITES-1:0]  id;
    logic [NUM_SITES-1:0]  mem;
    logic                  regs;
    logic                  dsp;
    logic                  ram;
    logic                  cid;
    logic                  rom;
    logic [HALF_OFF_W-1:0] wordOff;
  } decResult_t;
endpackage

// File: rtl/vme_dec_ctrl.sv
module vme_dec_ctrl
  import vme_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       asN,
  input  logic       iackN,
  output decStrobe_t strobe
);
  logic asPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) asPrev <= 1'b1;
    else       asPrev <= asN;
  end

  // load only on the first low sample; interrupt acknowledge cycles never load
  always_comb begin
    strobe.capture = asPrev & ~asN & iackN;
    strobe.clear   = asN;
  end
endmodule

// File: rtl/vme_dec_path.sv
module vme_dec_path
  import vme_dec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  decStrobe_t           strobe,
  input  logic [ADDR_HI:1]     vmeAddr,
  input  logic [AM_W-1:0]      amCode,
  input  logic                 lwordN,
  input  logic [SLOT_W-1:0]    slotAddr,
  input  logic [OFSREG_W-1:0]  offsetReg,
  input  logic                 memBaseSel,
  input  logic [SIZE_W-1:0]    memSize,
  output decResult_t           held,
  output logic                 claim
);
  logic amShort, amStd, amRom, amMem;
  logic regWinHit, regLocal;
  logic [NUM_SITES-1:0] ioHit, idHit, memSel;
  logic hitRegs, hitDsp, hitRam, hitCid, hitRom;
  logic [4:0]  sizeSh, winBits;
  logic [31:0] addrFull, addrShifted, baseShifted;
  logic ofsHit, slotHit, memHit;
  logic [SITE_IDX_W-1:0] memSite;
  logic [HALF_OFF_W-1:0] memHalf, halfOff;
  decResult_t nxt;

  assign amShort = (amCode == AM_SHORT_USER) || (amCode == AM_SHORT_SUP);
  assign amStd   = (amCode == AM_STD_USER)   || (amCode == AM_STD_SUP);
  assign amRom   = (amCode == AM_CFG_ROM);
  assign amMem   = (amCode == AM_EXT_USER)   || (amCode == AM_EXT_SUP);

  // register window: short and standard spaces share one 2 KB map
  assign regWinHit = (amShort && vmeAddr[15:11] == slotAddr) ||
                     ((amStd || amRom) && vmeAddr[23:19] == slotAddr);
  assign regLocal  = regWinHit && !amRom;

  genvar g;
  generate
    for (g = 0; g < NUM_SITES; g++) begin : g_siteReg
      assign ioHit[g] = regLocal && !vmeAddr[10] &&
                        (vmeAddr[9:8] == SITE_IDX_W'(g)) && !vmeAddr[7];
      assign idHit[g] = regLocal && !vmeAddr[10] &&
                        (vmeAddr[9:8] == SITE_IDX_W'(g)) && vmeAddr[7];
    end
  endgenerate

  assign hitRegs = regLocal && (vmeAddr[10:5] == 6'b100000);
  assign hitDsp  = regLocal && (vmeAddr[10:5] == 6'b100001);
  assign hitRam  = regLocal && (vmeAddr[10:6] == 5'b10001);
  assign hitCid  = regLocal && (vmeAddr[10:7] == 4'b1001);
  assign hitRom  = regWinHit && (vmeAddr[10:9] == 2'b11);

  // memory windows: span of four sites is 4 MB << memSize
  assign sizeSh      = 5'd22 + {3'b000, memSize};
  assign winBits     = 5'd19 + {3'b000, memSize};
  assign addrFull    = {vmeAddr, 1'b0};
  assign addrShifted = addrFull >> sizeSh;
  assign baseShifted = {offsetReg, 16'h0000} >> sizeSh;
  assign ofsHit      = (addrShifted == baseShifted);

  always_comb begin
    case (memSize)
      2'd0, 2'd1: slotHit = (addrShifted[SLOT_W-1:0] == slotAddr) &&
                            (addrShifted[31:SLOT_W] == '0);
      2'd3:       slotHit = (vmeAddr[31:27] == slotAddr) && (vmeAddr[26:25] == 2'b00);
      default:    slotHit = 1'b0;
    endcase
  end

  always_comb begin
    case (memSize)
      2'd0:    memSite = vmeAddr[21:20];
      2'd1:    memSite = vmeAddr[22:21];
      2'd2:    memSite = vmeAddr[23:22];
      default: memSite = vmeAddr[24:23];
    endcase
  end

  assign memHit  = amMem && (memBaseSel ? ofsHit : slotHit);
  assign memHalf = vmeAddr[22:1] & ((HALF_OFF_W'(1) << winBits) - HALF_OFF_W'(1));

  generate
    for (g = 0; g < NUM_SITES; g++) begin : g_siteMem
      assign memSel[g] = memHit && (memSite == SITE_IDX_W'(g));
    end
  endgenerate

  always_comb begin
    halfOff = '0;
    if (memHit)                    halfOff = memHalf;
    else if (|(ioHit | idHit))     halfOff = HALF_OFF_W'(vmeAddr[6:1]);
    else if (hitRegs || hitDsp)    halfOff = HALF_OFF_W'(vmeAddr[4:1]);
    else if (hitRam)               halfOff = HALF_OFF_W'(vmeAddr[5:1]);
    else if (hitCid)               halfOff = HALF_OFF_W'(vmeAddr[6:1]);
    else if (hitRom)               halfOff = HALF_OFF_W'(vmeAddr[8:1]);
  end

  always_comb begin
    nxt.io      = ioHit;
    nxt.id      = idHit;
    nxt.mem     = memSel;
    nxt.regs    = hitRegs;
    nxt.dsp     = hitDsp;
    nxt.ram     = hitRam;
    nxt.cid     = hitCid;
    nxt.rom     = hitRom;
    nxt.wordOff = lwordN ? halfOff : (halfOff >> 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      held  <= '0;
      claim <= 1'b0;
    end else if (strobe.clear) begin
      held  <= '0;
      claim <= 1'b0;
    end else if (strobe.capture) begin
      held  <= nxt;
      claim <= |{ioHit, idHit, memSel, hitRegs, hitDsp, hitRam, hitCid, hitRom};
    end
  end
endmodule

// File: rtl/vmeSlaveDecode.sv
module vmeSlaveDecode
  import vme_dec_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  asN,
  input  logic                  iackN,
  input  logic                  lwordN,
  input  logic [AM_W-1:0]       amCode,
  input  logic [ADDR_HI:1]      vmeAddr,
  input  logic [SLOT_W-1:0]     slotAddr,
  input  logic [OFSREG_W-1:0]   offsetReg,
  input  logic                  memBaseSel,
  input  logic [SIZE_W-1:0]     memSize,
  output logic [NUM_SITES-1:0]  selIo,
  output logic [NUM_SITES-1:0]  selId,
  output logic [NUM_SITES-1:0]  selMem,
  output logic                  selRegs,
  output logic                  selDsp,
  output logic                  selRam,
  output logic                  selCarrierId,
  output logic                  selCfgRom,
  output logic [HALF_OFF_W-1:0] wordOff,
  output logic                  claim
);
  decStrobe_t strobe;
  decResult_t held;

  vme_dec_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .asN(asN), .iackN(iackN), .strobe(strobe)
  );

  vme_dec_path path_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .vmeAddr(vmeAddr), .amCode(amCode),
    .lwordN(lwordN), .slotAddr(slotAddr), .offsetReg(offsetReg),
    .memBaseSel(memBaseSel), .memSize(memSize), .held(held), .claim(claim)
  );

  assign selIo        = held.io;
  assign selId        = held.id;
  assign selMem       = held.mem;
  assign selRegs      = held.regs;
  assign selDsp       = held.dsp;
  assign selRam       = held.ram;
  assign selCarrierId = held.cid;
  assign selCfgRom    = held.rom;
  assign wordOff      = held.wordOff;
endmodule

// File: rtl/vmeSlaveDecode_chk.sv
module vmeSlaveDecode_chk
  import vme_dec_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 asN,
  input logic                 iackN,
  input logic [AM_W-1:0]      amCode,
  input logic [NUM_SITES-1:0] selIo,
  input logic [NUM_SITES-1:0] selId,
  input logic [NUM_SITES-1:0] selMem,
  input logic                 selRegs,
  input logic                 selDsp,
  input logic                 selRam,
  input logic                 selCarrierId,
  input logic                 selCfgRom,
  input logic                 claim
);
  logic [3*NUM_SITES+4:0] selVec;
  logic asSeen, amKnown;

  assign selVec  = {selIo, selId, selMem, selRegs, selDsp, selRam, selCarrierId, selCfgRom};
  assign amKnown = amCode inside {6'h29, 6'h2D, 6'h39, 6'h3D, 6'h2F, 6'h09, 6'h0D};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) asSeen <= 1'b1;
    else       asSeen <= asN;
  end

  // R10
  one_select_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(selVec));
  // R10
  claim_match_chk: assert property (@(posedge clk) disable iff (!rstN) claim == (selVec != '0));
  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rstN) asN |=> (selVec == '0 && !claim));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN) (!asN && !asSeen) |=> $stable(selVec));
  // R8
  bad_am_chk: assert property (@(posedge clk) disable iff (!rstN) (!asN && asSeen && !amKnown) |=> selVec == '0);
  // R8
  iack_chk: assert property (@(posedge clk) disable iff (!rstN) (!asN && asSeen && !iackN) |=> selVec == '0);
endmodule

bind vmeSlaveDecode vmeSlaveDecode_chk chk_i (.*);

// File: tb/vmeSlaveDecode_tb_top.sv
module vmeSlaveDecode_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic asN = 1'b1, iackN = 1'b1, lwordN = 1'b1;
  logic [5:0]  amCode = 6'h3F;
  logic [31:1] vmeAddr = '0;
  logic [4:0]  slotAddr = 5'h0A;
  logic [15:0] offsetReg = '0;
  logic memBaseSel = 1'b0;
  logic [1:0] memSize = 2'd0;
  logic [3:0] selIo, selId, selMem;
  logic selRegs, selDsp, selRam, selCarrierId, selCfgRom, claim;
  logic [21:0] wordOff;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vmeSlaveDecode dut_i (.*);

  localparam logic [16:0] NONE = 17'd0, REGS = 17'd1 << 4, DSP = 17'd1 << 3,
                          RAM = 17'd1 << 2, CID = 17'd1 << 1, ROM = 17'd1;
  function automatic logic [16:0] fIo(int i);  return 17'd1 << (13 + i); endfunction
  function automatic logic [16:0] fId(int i);  return 17'd1 << (9 + i);  endfunction
  function automatic logic [16:0] fMem(int i); return 17'd1 << (5 + i);  endfunction

  function automatic logic [16:0] gotSel();
    return {selIo, selId, selMem, selRegs, selDsp, selRam, selCarrierId, selCfgRom};
  endfunction

  task automatic checkOut(input string tag, input logic [16:0] expSel, input logic [21:0] expOff);
    checks++;
    if (gotSel() !== expSel || wordOff !== expOff || claim !== (expSel != 0)) begin
      errors++;
      $display("FAIL %s: sel=%h off=%h claim=%b expected sel=%h off=%h claim=%b",
               tag, gotSel(), wordOff, claim, expSel, expOff, expSel != 0);
    end
  endtask

  task automatic startCycle(input logic [5:0] am, input logic [31:0] a, input logic lw, input logic ia);
    @(negedge clk);
    amCode = am; vmeAddr = a[31:1]; lwordN = lw; iackN = ia; asN = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic endCycle(input string tag);
    asN = 1'b1; iackN = 1'b1;
    @(posedge clk); @(negedge clk);
    checkOut({tag, " R9 release"}, NONE, '0);
  endtask

  task automatic runCase(input string tag, input logic [5:0] am, input logic [31:0] a,
                         input logic lw, input logic ia, input logic [16:0] expSel,
                         input logic [21:0] expOff);
    startCycle(am, a, lw, ia);
    checkOut(tag, expSel, expOff);
    endCycle(tag);
  endtask

  task automatic testReset();
    checkOut("R10 reset", NONE, '0);
  endtask

  task automatic testShort();
    runCase("R1 short 29 site B io", 6'h29, 32'h0000_5102, 1'b1, 1'b1, fIo(1), 22'd1);
    runCase("R1 short 2D site D id", 6'h2D, 32'h0000_538A, 1'b1, 1'b1, fId(3), 22'd5);
    runCase("R8 short slot mismatch", 6'h29, 32'h0000_5900, 1'b1, 1'b1, NONE, '0);
  endtask

  task automatic testStandard();
    runCase("R2 std 39 regs", 6'h39, 32'h0050_0404, 1'b1, 1'b1, REGS, 22'd2);
    runCase("R7 std regs 32-bit", 6'h39, 32'h0050_0404, 1'b0, 1'b1, REGS, 22'd1);
    runCase("R2 std 3D dsp", 6'h3D, 32'h0050_042A, 1'b1, 1'b1, DSP, 22'd5);
    runCase("R3 shared ram", 6'h39, 32'h0050_0450, 1'b1, 1'b1, RAM, 22'd8);
    runCase("R3 carrier id", 6'h39, 32'h0050_04A0, 1'b1, 1'b1, CID, 22'h10);
    runCase("R3 gap 0x550", 6'h39, 32'h0050_0550, 1'b1, 1'b1, NONE, '0);
    runCase("R3 rom top", 6'h39, 32'h0050_07FE, 1'b1, 1'b1, ROM, 22'hFF);
    runCase("R3 site A io base", 6'h3D, 32'h0050_0000, 1'b1, 1'b1, fIo(0), 22'd0);
  endtask

  task automatic testRomAm();
    runCase("R4 2F rom", 6'h2F, 32'h0050_0604, 1'b1, 1'b1, ROM, 22'd2);
    runCase("R4 2F outside rom", 6'h2F, 32'h0050_0010, 1'b1, 1'b1, NONE, '0);
  endtask

  task automatic testRejects();
    runCase("R8 unknown am", 6'h3A, 32'h0050_0404, 1'b1, 1'b1, NONE, '0);
    runCase("R8 iack cycle", 6'h29, 32'h0000_5102, 1'b1, 1'b0, NONE, '0);
  endtask

  task automatic testOffsetMode();
    memBaseSel = 1'b1; memSize = 2'd3; offsetReg = 16'h8600;
    runCase("R5 ofs 8MB site C", 6'h09, 32'h8700_0010, 1'b1, 1'b1, fMem(2), 22'd8);
    offsetReg = 16'h87C0;
    runCase("R5 ofs low bits ignored", 6'h0D, 32'h8700_0010, 1'b0, 1'b1, fMem(2), 22'd4);
    memSize = 2'd0; offsetReg = 16'h1240;
    runCase("R5 ofs 1MB site D", 6'h09, 32'h1270_0020, 1'b1, 1'b1, fMem(3), 22'h10);
    runCase("R5 ofs 1MB beyond span", 6'h09, 32'h1280_0020, 1'b1, 1'b1, NONE, '0);
  endtask

  task automatic testSlotMode();
    memBaseSel = 1'b0; memSize = 2'd0;
    runCase("R6 slot 1MB site B", 6'h09, 32'h0290_0004, 1'b1, 1'b1, fMem(1), 22'd2);
    runCase("R6 slot 1MB upper set", 6'h09, 32'h0A90_0004, 1'b1, 1'b1, NONE, '0);
    memSize = 2'd1;
    runCase("R6 slot 2MB site D", 6'h0D, 32'h0560_0006, 1'b1, 1'b1, fMem(3), 22'd3);
    memSize = 2'd2;
    runCase("R6 slot 4MB rejected", 6'h09, 32'h0290_0004, 1'b1, 1'b1, NONE, '0);
    memSize = 2'd3;
    runCase("R6 slot 8MB site B", 6'h09, 32'h5080_0008, 1'b1, 1'b1, fMem(1), 22'd4);
    runCase("R6 slot 8MB gap bit set", 6'h09, 32'h5280_0008, 1'b1, 1'b1, NONE, '0);
  endtask

  task automatic testHold();
    startCycle(6'h29, 32'h0000_5102, 1'b1, 1'b1);
    checkOut("R9 hold initial", fIo(1), 22'd1);
    amCode = 6'h39; vmeAddr = 31'h0; lwordN = 1'b0; memSize = 2'd2;
    @(posedge clk); @(posedge clk); @(negedge clk);
    checkOut("R9 hold after input change", fIo(1), 22'd1);
    endCycle("R9 hold");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testShort();
    testStandard();
    testRomAm();
    testRejects();
    testOffsetMode();
    testSlotMode();
    testHold();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule